// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a UART reference clock into the enable strobes that pace a serial link. A divisor made of a 16-bit whole part and a 6-bit fraction, counted in sixty-fourths, sets the spacing of an oversampling strobe. The strobe rate is the reference clock divided by (whole + fraction/64). Because the link oversamples each bit sixteen times, the bit rate equals the reference clock divided by sixteen times that divisor. A second strobe marks every sixteenth oversampling strobe and paces the transmitter one bit at a time.

A fractional divisor cannot be met by any single period length. The block instead makes each period either the whole value or one clock longer. A 6-bit phase accumulator grows by the fraction once per period, and its carry decides which periods get the extra clock. The error therefore never builds up, and any 64 consecutive periods add up to the exact target. A load strobe latches a new divisor and restarts the counting from a clean state. Loading a whole part of zero stops both strobes.

Top module: `baud_frac_tick_gen`

## Requirements
- R1: While reset is low and after it is released, both strobes stay low until a non-zero divisor is loaded.
- R2: A cycle with `div_load` high latches `div_int`/`div_frac` at that clock edge. The first oversampling strobe is high in the cycle after the L-th following edge, where L is the length of period 0.
- R3: Every interval between consecutive oversampling strobes lasts either `div_int` or `div_int`+1 clocks.
- R4: Periods are numbered k = 0,1,2… from the load. Period k lasts `div_int`+1 clocks exactly when floor((k+1)·F/64) > floor(k·F/64), with F the fraction.
- R5: Any 64 consecutive strobe intervals together span exactly 64·`div_int` + `div_frac` clocks.
- R6: A loaded whole part of zero keeps both strobes low for as long as it stays loaded.
- R7: The oversampling strobe is one clock wide. With a whole part of 2 or more, it is never high in two adjacent cycles.
- R8: `bit_tick` is high only together with `os_tick`, on the 16th, 32nd, … oversampling strobe counted from the load.
- R9: A fraction of zero gives a fixed period equal to the whole part. A whole part of 1 with fraction 0 gives a strobe in every cycle.
- R10: A load in the middle of a period discards the partial period and the accumulated phase.
- R11: Changes on `div_int`/`div_frac` while `div_load` is low have no effect on the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UART reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_load | input | 1 | Latch the divisor inputs and restart |
| div_int | input | 16 | Whole part of the divisor; 0 stops the strobes |
| div_frac | input | 6 | Fractional part of the divisor, in 1/64 steps |
| os_tick | output | 1 | Oversampling strobe, one clock wide |
| bit_tick | output | 1 | Bit strobe, every 16th oversampling strobe |

## Verification
Several properties are checked on every clock:
- the quiet outputs after reset and while the whole part is zero;
- the absence of a strobe right after a load;
- the spacing of every interval, which must be the whole part or one more;
- the single-cycle width of the strobe;
- the bit strobe appearing only on top of an oversampling strobe.

Other behaviour can only be shown by the bench's scenarios. These include the exact positions of the stretched periods and the exact span of 64 intervals for a given fraction. They also include the phase of the bit strobe after a load, the restart in the middle of a period, and the way unlatched divisor changes are ignored. A behavioural model computes each period from a closed-form floor expression and is compared against the outputs on every clock.

// File: rtl/baud_tick_pkg.sv
// Package: default widths shared by the tick generator and its checker.
package baud_tick_pkg;
    localparam int unsigned BT_INT_W  = 16;  // whole divisor width
    localparam int unsigned BT_FRAC_W = 6;   // fractional divisor width (1/64 steps)
    localparam int unsigned BT_OSR    = 16;  // oversampling strobes per bit

    // Registered strobe pair leaving the generator.
    typedef struct packed {
        logic os;
        logic bit_s;
    } tick_pair_t;
endpackage

// File: rtl/baud_frac_accum.sv
// Fractional phase accumulator.
// Adds the fraction once per completed period; the carry of the pending
// addition tells the period counter to stretch the current period by one.
// Assumes clr and adv are never needed together (clr wins).
module baud_frac_accum #(
    parameter int unsigned FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic [FRAC_W-1:0] frac,
    output logic              extend
);
    logic [FRAC_W-1:0] phase_q;
    logic [FRAC_W:0]   sum;

    // Pending sum of phase and fraction; its top bit is the carry.
    always_comb begin
        sum    = {1'b0, phase_q} + {1'b0, frac};
        extend = sum[FRAC_W];
    end

    // Phase register: cleared on reset or restart, stepped per period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase_q <= '0;
        end else if (adv) begin
            phase_q <= sum[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/baud_period_ctr.sv
// Period counter.
// Counts reference clocks and flags the last clock of a period whose length
// is the whole divisor, plus one when 'extend' is set. A whole divisor of
// zero holds the counter idle. Assumes the divisor is stable between clears.
module baud_period_ctr #(
    parameter int unsigned INT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [INT_W-1:0] whole,
    input  logic             extend,
    output logic             period_end
);
    localparam int unsigned CW = INT_W + 1;

    logic [INT_W-1:0] cnt_q;
    logic [CW-1:0]    last_idx;
    logic             active;

    // Index of the final clock of this period and the end-of-period flag.
    always_comb begin
        active     = (whole != '0);
        last_idx   = {1'b0, whole} + {{INT_W{1'b0}}, extend} - CW'(1);
        period_end = active && ({1'b0, cnt_q} == last_idx);
    end

    // Clock counter: restarts on clear, idle, or end of period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !active) begin
            cnt_q <= '0;
        end else if (period_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + INT_W'(1);
        end
    end
endmodule

// File: rtl/baud_bit_div.sv
// Oversample-to-bit divider.
// Counts period ends and flags every OSR-th one. Assumes OSR >= 2.
module baud_bit_div #(
    parameter int unsigned OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic bit_end
);
    localparam int unsigned OS_W = (OSR > 2) ? $clog2(OSR) : 1;

    logic [OS_W-1:0] os_cnt_q;

    // Bit boundary when the final oversample of a bit completes.
    always_comb begin
        bit_end = adv && (os_cnt_q == OS_W'(OSR - 1));
    end

    // Oversample counter: restarts on clear and at each bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            os_cnt_q <= '0;
        end else if (adv) begin
            os_cnt_q <= bit_end ? '0 : os_cnt_q + OS_W'(1);
        end
    end
endmodule

// File: rtl/baud_frac_tick_gen.sv
// Fractional baud tick generator (top).
// Latches a whole+fraction divisor on div_load. It then emits a one-clock
// oversampling strobe per period, where each period lasts whole or whole+1
// clocks as picked by the phase accumulator carry. It also emits a bit strobe
// on every OSR-th oversampling strobe. Runs entirely in the reference clock
// domain. Assumes the divisor inputs are valid whenever div_load is high.
module baud_frac_tick_gen
    import baud_tick_pkg::*;
#(
    parameter int unsigned INT_W  = BT_INT_W,
    parameter int unsigned FRAC_W = BT_FRAC_W,
    parameter int unsigned OSR    = BT_OSR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_load,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              os_tick,
    output logic              bit_tick
);
    logic [INT_W-1:0]  int_q;
    logic [FRAC_W-1:0] frac_q;
    logic              extend;
    logic              period_end;
    logic              step;
    logic              bit_end;
    tick_pair_t        ticks_q;

    // Divisor latch: loaded only on an explicit load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q  <= '0;
            frac_q <= '0;
        end else if (div_load) begin
            int_q  <= div_int;
            frac_q <= div_frac;
        end
    end

    // A period only counts when no restart is under way.
    always_comb begin
        step = period_end && !div_load;
    end

    baud_frac_accum #(.FRAC_W(FRAC_W)) accum_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (div_load),
        .adv    (step),
        .frac   (frac_q),
        .extend (extend)
    );

    baud_period_ctr #(.INT_W(INT_W)) period_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (div_load),
        .whole      (int_q),
        .extend     (extend),
        .period_end (period_end)
    );

    baud_bit_div #(.OSR(OSR)) bitdiv_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (div_load),
        .adv     (step),
        .bit_end (bit_end)
    );

    // Output strobe registers: one clock wide, cleared by reset and restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ticks_q <= '0;
        end else begin
            ticks_q.os    <= step;
            ticks_q.bit_s <= bit_end && !div_load;
        end
    end

    assign os_tick  = ticks_q.os;
    assign bit_tick = ticks_q.bit_s;
endmodule

// File: rtl/baud_frac_tick_chk.sv
// Checker for baud_frac_tick_gen, attached by bind.
// Measures strobe spacing with its own counter, so no deep $past is needed.
module baud_frac_tick_chk #(
    parameter int unsigned INT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic [INT_W-1:0] cfg_int,
    input logic             os_tick,
    input logic             bit_tick
);
    logic             past_valid = 1'b0;
    logic [INT_W+1:0] gap_q;
    logic             have_prev_q;

    // Marks that at least one clock edge has passed.
    always_ff @(posedge clk) past_valid <= 1'b1;

    // Clocks since the last observed strobe; cleared by restart or idle.
    always_ff @(posedge clk) begin
        if (!rst_n || load || cfg_int == '0) begin
            gap_q       <= '0;
            have_prev_q <= 1'b0;
        end else if (os_tick) begin
            gap_q       <= (INT_W+2)'(1);
            have_prev_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + (INT_W+2)'(1);
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && $past(!rst_n) |-> !os_tick && !bit_tick);

    p_restart_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && $past(load) |-> !os_tick);

    p_period_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick && have_prev_q && !$past(load) |->
            (gap_q == {2'b00, cfg_int}) || (gap_q == {2'b00, cfg_int} + (INT_W+2)'(1)));

    p_idle_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && cfg_int == '0 |-> !os_tick && !bit_tick);

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick && cfg_int > INT_W'(1) && !load |=> !os_tick);

    p_bit_on_os_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);
endmodule

bind baud_frac_tick_gen baud_frac_tick_chk #(.INT_W(INT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (div_load),
    .cfg_int  (int_q),
    .os_tick  (os_tick),
    .bit_tick (bit_tick)
);

// File: tb/baud_frac_tick_gen_tb_top.sv
`timescale 1ns/1ps
module baud_frac_tick_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_load = 1'b0;
    logic [15:0] div_int = '0;
    logic [5:0]  div_frac = '0;
    logic        os_tick;
    logic        bit_tick;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 1'b0;
    bit    cmp_on   = 1'b0;
    string cur_req  = "R1";

    // behavioural model state
    int m_int = 0, m_frac = 0, m_el = 0, m_k = 0, m_osn = 0;
    bit exp_os = 1'b0, exp_bit = 1'b0;

    int tq[$];
    int bit_seen;
    int cyc = 0;

    always #2.5 clk = ~clk;

    baud_frac_tick_gen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_load (div_load),
        .div_int  (div_int),
        .div_frac (div_frac),
        .os_tick  (os_tick),
        .bit_tick (bit_tick)
    );

    // Reference model: period k of a load lasts int + (floor((k+1)F/64) - floor(kF/64)).
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_int = 0; m_frac = 0; m_el = 0; m_k = 0; m_osn = 0;
            exp_os = 0; exp_bit = 0;
        end else if (div_load) begin
            m_int = div_int; m_frac = div_frac; m_el = 0; m_k = 0; m_osn = 0;
            exp_os = 0; exp_bit = 0;
        end else if (m_int == 0) begin
            exp_os = 0; exp_bit = 0;
        end else begin
            int len;
            len = m_int + ((m_k + 1) * m_frac / 64 - m_k * m_frac / 64);
            m_el++;
            if (m_el == len) begin
                exp_os = 1; m_el = 0; m_k = (m_k + 1) % 64; m_osn++;
                if (m_osn == 16) begin exp_bit = 1; m_osn = 0; end
                else exp_bit = 0;
            end else begin
                exp_os = 0; exp_bit = 0;
            end
        end
    end

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            n_checks++;
            if (os_tick !== exp_os || bit_tick !== exp_bit) begin
                n_fail++;
                $display("FAIL %s cycle %0d: os=%0b bit=%0b expected os=%0b bit=%0b",
                         cur_req, cyc, os_tick, bit_tick, exp_os, exp_bit);
            end
        end
    end

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic load_div(input int w, input int f);
        @(negedge clk);
        div_int = 16'(w); div_frac = 6'(f); div_load = 1'b1;
        @(negedge clk);
        div_load = 1'b0;
    endtask

    // Negedges from the end of a load until the first strobe.
    task automatic first_tick(output int n);
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            n++;
            if (os_tick) break;
        end
    endtask

    // Record the cycle number of the next 'cnt' strobes and count bit strobes.
    task automatic collect(input int cnt);
        tq.delete();
        bit_seen = 0;
        for (int i = 0; i < 20000 && tq.size() < cnt; i++) begin
            @(negedge clk);
            if (os_tick) tq.push_back(cyc);
            if (bit_tick) bit_seen++;
        end
    endtask

    // Number of intervals in tq not equal to lo or hi.
    function automatic int bad_gaps(input int lo, input int hi);
        int bad = 0;
        for (int i = 1; i < tq.size(); i++) begin
            int g = tq[i] - tq[i-1];
            if (g != lo && g != hi) bad++;
        end
        return bad;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R1", {31'd0, os_tick | bit_tick}, 0);      // R1 in reset
        rst_n = 1'b1;
        cmp_on = 1'b1;
        cur_req = "R1";
        collect(1);
        check("R1", tq.size(), 0);                          // R1 no strobe unloaded

        cur_req = "R2";
        load_div(5, 0);
        first_tick(n);
        check("R2", n, 5);                                  // R2 first strobe timing

        cur_req = "R9";
        collect(20);
        check("R9", bad_gaps(5, 5), 0);                     // R9 fixed period

        cur_req = "R4";
        load_div(4, 21);
        collect(130);
        check("R3", bad_gaps(4, 5), 0);                     // R3 lengths
        check("R5", tq[64] - tq[0], 64 * 4 + 21);           // R5 window
        check("R5", tq[100] - tq[36], 64 * 4 + 21);         // R5 shifted window
        check("R8", bit_seen, 8);                           // R8 bit strobes in 130 (first at 16th)

        cur_req = "R9";
        load_div(1, 0);
        collect(30);
        check("R9", tq[29] - tq[0], 29);                    // R9 every cycle

        cur_req = "R5";
        load_div(1, 63);
        collect(70);
        check("R5", tq[65] - tq[1], 64 + 63);               // R5 extreme fraction
        check("R3", bad_gaps(1, 2), 0);                     // R3

        cur_req = "R7";
        load_div(7, 0);
        collect(10);
        check("R7", bad_gaps(7, 7), 0);                     // R7 no adjacent strobes

        cur_req = "R10";
        load_div(6, 40);
        repeat (4) @(negedge clk);
        load_div(3, 0);
        first_tick(n);
        check("R10", n, 3);                                 // R10 partial period dropped

        cur_req = "R11";
        @(negedge clk);
        div_int = 16'd9; div_frac = 6'd50;
        collect(12);
        check("R11", bad_gaps(3, 3), 0);                    // R11 unlatched inputs ignored

        cur_req = "R6";
        load_div(0, 9);
        collect(1);
        check("R6", tq.size(), 0);                          // R6 zero stops strobes

        cur_req = "R2";
        load_div(2, 0);
        first_tick(n);
        check("R2", n, 2);                                  // R2 restart after idle

        cur_req = "R8";
        load_div(3, 17);
        collect(40);
        check("R8", bit_seen, 2);                           // R8 16th and 32nd strobe

        cmp_on = 1'b0;
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule